// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block decides whether a serial write frame also commits the 8-bit setting to a nonvolatile shadow copy, and it runs that commit. The serial front end raises a one-clock strobe when the last data bit of a frame arrives. On the next clock the sequencer samples the program request together with chip select and a supply-adequate flag. If all three are high and no commit is already running, it captures the setting and drops its active-low ready output. It also raises an inhibit line so that the serial interface ignores input and drives no output.

The erase/write cycle lasts a fixed, parameterised number of clocks, and the clock has to keep running for the whole cycle. At the end, ready returns high and a one-clock store enable writes the captured value into the shadow store. If the supply flag is low when the request is sampled, the command is refused. Ready then never goes low, and the shadow copy keeps its old contents.

Top module: `nv_store_seq`

## Requirements
- R1: After synchronous reset, ready_o is 1, inhibit_o is 0, store_en_o is 0 and shadow_o equals INIT_VAL (default 8'h00).
- R2: If d7_stb_i is high at clock edge N, and cs_i, prog_i and supply_ok_i are all high at edge N+1 while idle, then ready_o is 0 from edge N+1.
- R3: Once ready_o falls, it stays 0 for exactly PROG_CYCLES clocks (default 64) and then returns to 1.
- R4: inhibit_o is 1 exactly while ready_o is 0 and 0 otherwise.
- R5: store_en_o is high for one clock, starting at the edge where ready_o returns to 1. At the following edge shadow_o takes the value setting_i had at the request edge, and later changes to setting_i do not affect it.
- R6: If prog_i is low at the sampling edge, no cycle starts: ready_o stays 1 and shadow_o is unchanged.
- R7: If supply_ok_i is low at the sampling edge, the store is refused: ready_o stays 1, store_en_o stays 0 and shadow_o is unchanged.
- R8: A strobe and program request that arrive while a cycle is running are ignored. The running cycle keeps its length and stores its first captured value.
- R9: If cs_i is low at the sampling edge, no cycle starts and shadow_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which must keep running during the write cycle |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select of the serial frame |
| prog_i | input | 1 | Program request, sampled on the clock after the last data bit |
| d7_stb_i | input | 1 | One-clock strobe marking receipt of the last data bit |
| setting_i | input | DATA_W | Current setting register value |
| supply_ok_i | input | 1 | High when the supply is adequate for programming |
| ready_o | output | 1 | Ready/busy, low while an erase/write cycle runs |
| store_en_o | output | 1 | One-clock write enable to the shadow store |
| inhibit_o | output | 1 | Tells the serial interface to ignore DI and leave DO undriven |
| shadow_o | output | DATA_W | Contents of the nonvolatile shadow store |

## Verification
The assertions assume that d7_stb_i lasts one clock per frame and that supply_ok_i, prog_i and cs_i are stable across the sampling edge. The assertions make no assumption about setting_i. The stimulus changes inputs only on falling clock edges and holds each strobe for exactly one clock. It also changes setting_i right after each request, so that a late capture would show up. One frame raises a second strobe and program request in the middle of a busy cycle, to check that they are ignored.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // Sequencer phase: either waiting for a request or running a write cycle.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BUSY = 1'b1
  } nvs_phase_t;

  // Minimum legal write-cycle length (needed for the counter compare).
  localparam int unsigned MIN_CYCLES = 2;

endpackage

// File: rtl/nvs_arm.sv
module nvs_arm #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d7_stb,
  input  logic              cs,
  input  logic              prog,
  input  logic              supply_ok,
  input  logic              busy,
  input  logic [DATA_W-1:0] setting,
  output logic              start,
  output logic [DATA_W-1:0] cap_val
);

  // One clock after the last data bit: the window in which PROG is looked at.
  logic pend_q;
  logic request;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= d7_stb & cs;
    end
  end

  // A request exists only in the sampling clock, with CS still high and no
  // cycle running; the supply flag then decides whether it is honoured.
  always_comb begin
    request = pend_q & cs & prog & ~busy;
    start   = request & supply_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
    end else if (start) begin
      cap_val <= setting;
    end
  end

  // Captured value only moves on an accepted request.
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(start) |-> $stable(cap_val)); // R5

  // Nothing starts while a cycle is running.
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start); // R8

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer
  import nvs_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int unsigned CNT_W   = (PROG_CYCLES > 2) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  nvs_phase_t       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  initial begin
    if (PROG_CYCLES < MIN_CYCLES) $error("PROG_CYCLES must be at least 2");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start) begin
            phase_q <= PH_BUSY;
          end
        end
        PH_BUSY: begin
          if (cnt_q == LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase_q == PH_BUSY);
  assign done = done_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= LAST)); // R3

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cnt_q == '0)); // R3

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R5

endmodule

// File: rtl/nvs_shadow.sv
module nvs_shadow #(
  parameter int unsigned     DATA_W   = 8,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  // Single-word store, written as a one-entry array.
  logic [DATA_W-1:0] cell_q [1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_q[0] <= INIT_VAL;
    end else if (we) begin
      cell_q[0] <= wdata;
    end
  end

  assign rdata = cell_q[0];

  AST_SHADOW_ONLY_ON_WE: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(rdata)); // R7

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       PROG_CYCLES = 64,
  parameter logic [DATA_W-1:0] INIT_VAL    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              prog_i,
  input  logic              d7_stb_i,
  input  logic [DATA_W-1:0] setting_i,
  input  logic              supply_ok_i,
  output logic              ready_o,
  output logic              store_en_o,
  output logic              inhibit_o,
  output logic [DATA_W-1:0] shadow_o
);

  logic              start;
  logic              busy;
  logic              done;
  logic [DATA_W-1:0] cap_val;

  nvs_arm #(
    .DATA_W (DATA_W)
  ) u_arm (
    .clk       (clk),
    .rst       (rst),
    .d7_stb    (d7_stb_i),
    .cs        (cs_i),
    .prog      (prog_i),
    .supply_ok (supply_ok_i),
    .busy      (busy),
    .setting   (setting_i),
    .start     (start),
    .cap_val   (cap_val)
  );

  nvs_timer #(
    .PROG_CYCLES (PROG_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  nvs_shadow #(
    .DATA_W   (DATA_W),
    .INIT_VAL (INIT_VAL)
  ) u_shadow (
    .clk   (clk),
    .rst   (rst),
    .we    (done),
    .wdata (cap_val),
    .rdata (shadow_o)
  );

  assign ready_o    = ~busy;
  assign inhibit_o  = busy;
  assign store_en_o = done;

  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> ($past(prog_i) && $past(cs_i))); // R2

  AST_BUSY_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> $past(supply_ok_i)); // R7

  AST_STORE_AT_READY: assert property (@(posedge clk) disable iff (rst)
    store_en_o |-> (ready_o && !$past(ready_o))); // R5

  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    store_en_o |=> !store_en_o); // R5

  AST_READY_RISE_STORES: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> store_en_o); // R3

endmodule

// File: tb/tb_nv_store_seq.sv
module tb_nv_store_seq;

  localparam int unsigned DW  = 8;
  localparam int unsigned CYC = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_i = 1'b0;
  logic          prog_i = 1'b0;
  logic          d7_stb_i = 1'b0;
  logic [DW-1:0] setting_i = '0;
  logic          supply_ok_i = 1'b1;
  logic          ready_o;
  logic          store_en_o;
  logic          inhibit_o;
  logic [DW-1:0] shadow_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] model_shadow = '0;

  nv_store_seq #(.DATA_W(DW), .PROG_CYCLES(CYC), .INIT_VAL(8'h00)) dut (
    .clk(clk), .rst(rst), .cs_i(cs_i), .prog_i(prog_i), .d7_stb_i(d7_stb_i),
    .setting_i(setting_i), .supply_ok_i(supply_ok_i), .ready_o(ready_o),
    .store_en_o(store_en_o), .inhibit_o(inhibit_o), .shadow_o(shadow_o)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: measures each busy window and compares the stored value.
  initial begin
    int  busy_len = 0;
    bit  was_busy = 1'b0;
    bit  pend_cmp = 1'b0;
    logic [DW-1:0] want = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (pend_cmp) begin
          check(shadow_o == want, "R5 shadow value", shadow_o, want);
          model_shadow = want;
          pend_cmp = 1'b0;
        end
        if (!ready_o) begin
          busy_len++;
          was_busy = 1'b1;
        end else if (was_busy) begin
          check(busy_len == CYC, "R3 busy length", busy_len, CYC);
          check(store_en_o == 1'b1, "R5 store enable at ready", store_en_o, 1);
          check(inhibit_o == 1'b0, "R4 inhibit released", inhibit_o, 0);
          if (exp_q.size() == 0) begin
            check(1'b0, "R5 unexpected store", 1, 0);
          end else begin
            want = exp_q.pop_front();
            pend_cmp = 1'b1;
          end
          busy_len = 0;
          was_busy = 1'b0;
        end
      end
    end
  end

  // Driver: one frame ending in the PROG sampling clock.
  task automatic frame(input logic [DW-1:0] val, input bit prog, input bit sel_at_sample,
                       input bit supply, input bit accept, input bit poke_busy,
                       input string req);
    @(negedge clk);
    cs_i = 1'b1; setting_i = val; d7_stb_i = 1'b1;
    @(negedge clk);
    d7_stb_i = 1'b0; prog_i = prog; cs_i = sel_at_sample; supply_ok_i = supply;
    if (accept) exp_q.push_back(val);
    @(negedge clk);
    prog_i = 1'b0; cs_i = 1'b0; supply_ok_i = 1'b1; setting_i = ~val;
    if (accept) begin
      check(ready_o == 1'b0, {req, " busy started"}, ready_o, 0);
      check(inhibit_o == 1'b1, "R4 inhibit while busy", inhibit_o, 1);
      if (poke_busy) begin
        repeat (10) @(negedge clk);
        cs_i = 1'b1; setting_i = 8'h5A; d7_stb_i = 1'b1;
        @(negedge clk);
        d7_stb_i = 1'b0; prog_i = 1'b1;
        @(negedge clk);
        prog_i = 1'b0; cs_i = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(ready_o == 1'b1, {req, " ready after cycle"}, ready_o, 1);
    end else begin
      for (int i = 0; i < 6; i++) begin
        check(ready_o == 1'b1, {req, " ready stays high"}, ready_o, 1);
        @(negedge clk);
      end
      check(store_en_o == 1'b0, {req, " no store enable"}, store_en_o, 0);
      check(shadow_o == model_shadow, {req, " shadow unchanged"}, shadow_o, model_shadow);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready_o == 1'b1, "R1 ready reset", ready_o, 1);
    check(inhibit_o == 1'b0, "R1 inhibit reset", inhibit_o, 0);
    check(store_en_o == 1'b0, "R1 store enable reset", store_en_o, 0);
    check(shadow_o == 8'h00, "R1 shadow reset", shadow_o, 0);

    frame(8'hA5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    frame(8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    frame(8'h77, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    frame(8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    frame(8'h42, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    frame(8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    check(shadow_o == 8'hFF, "R5 final shadow", shadow_o, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule